// File: doc/BRIEF.md
# Circuit Setup Mesh Router

This router sits at one hop of a narrow side mesh that carries requests to build circuits through a data mesh. Each request names a circuit plane, the node that is asking for the circuit and the node where the circuit ends. The request goes through an input buffer, wins an output link in a round-robin arbiter and is then forwarded to the neighbour. When it wins the link, the router writes the crossbar setting of the data-network router at this hop: on plane `circuit`, output `port` is now fed from input `in`. Data flits follow right behind a request and never wait for an acknowledgment.

The router keeps one record per circuit plane and output link, holding whether the link is in use and which source owns it. A request from a different source can take a link that is already in use. When that happens, the router strobes a retag indication for that plane and link, so that later data flits of the old circuit drop to packet handling. In the same cycle it emits a notification flit addressed to the old owner. Notification flits use the request format with a marker bit set. They are routed the same way but never touch the crossbar settings or the records.

Top module: `setup_router`

## Requirements
- R1: While reset is held, every `out_valid`, `cfg_we`, `rcf_valid` and `ntf_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit is `{marker, src, dst, circuit}` from MSB to LSB. Node ids are `{y, x}`. Port codes are 0 local, 1 east (x+1), 2 west (x-1), 3 north (y+1) and 4 south (y-1). Routing corrects x before y and ejects on port 0 when `dst` equals this node. Flits leave unchanged, with no loss, duplication or reordering per path.
- R3: An uncontended flit accepted at clock edge k drives `cfg_we` after edge k+1 and `out_valid` after edge k+2 on its output port.
- R4: A request (marker 0) that wins output port o pulses `cfg_we[o]` for one cycle, with `cfg_circ[o]` equal to its circuit and `cfg_in[o]` equal to its input port code.
- R5: If the record for (circuit, o) is in use by a different source, the same cycle carries `rcf_valid[o]`=1 with `rcf_circ[o]` equal to the circuit. It also carries `ntf_valid[o]`=1 with `ntf_flit[o]` = `{1, this node, old source, circuit}`. The record then holds the new source.
- R6: A request whose record is unused, or is held by the same source, gives `rcf_valid`=0 and `ntf_valid`=0. No retag or notification appears without a configuration write.
- R7: A flit with marker 1 is routed as in R2 but gives no `cfg_we`, and it leaves the records unchanged.
- R8: Inputs competing for one output are served round robin. After reset, the search starts at port 0. After a grant, it starts at the port above the last winner, wrapping from 4 to 0.
- R9: While `out_ready[o]` is 0, `out_valid[o]` and `out_flit[o]` hold. Each input buffers 4 flits, so an input feeding a stalled output accepts exactly 6 flits (buffer plus the two later stages) before `in_ready` drops.
- R10: Records are kept separately per circuit plane, so requests for different circuits on one output link never displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Flit present per input port |
| in_flit | input | 5 x FW | Incoming flits |
| in_ready | output | 5 | Input buffer has room |
| out_valid | output | 5 | Flit present per output port |
| out_flit | output | 5 x FW | Outgoing flits |
| out_ready | input | 5 | Neighbour accepts the flit |
| cfg_we | output | 5 | Crossbar setting write per output port |
| cfg_circ | output | 5 x CW | Circuit plane being written |
| cfg_in | output | 5 x 3 | Input port code driving that output |
| rcf_valid | output | 5 | Retag strobe: the link was taken from another circuit |
| rcf_circ | output | 5 x CW | Plane being retagged |
| ntf_valid | output | 5 | Notification flit present |
| ntf_flit | output | 5 x FW | Notification toward the displaced source |

## Verification
The bench builds a 4x4 mesh with four circuit planes and places the router at node (1,1). From that node every output direction, local ejection and an x-before-y choice can be reached. With four planes, the bench can show a takeover on one plane while another plane of the same link stays untouched. A four-entry buffer makes the stall depth a small, exact count.

// File: rtl/setup_rtr_pkg.sv
// Shared constants of the setup router: port count and port codes.
// Assumes a 2D mesh with one local port.
package setup_rtr_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;
    typedef enum logic [PW-1:0] {
        P_LOC   = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;
endpackage

// File: rtl/setup_fifo.sv
// Input buffer of one port. Writes happen on push, and the head is shown combinationally.
// Assumes DEPTH is a power of two and that pop is only raised while not empty.
module setup_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nempty,
    output logic         room
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] mem;
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign dout   = mem[rp];
    assign nempty = (cnt != '0);
    assign room   = (cnt < (AW+1)'(DEPTH));

    // Pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            mem <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (pop) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/setup_route.sv
// Dimension-ordered route choice: x is corrected first, then y.
// Assumes node ids are {y, x}. Gives a one-hot output port.
module setup_route
    import setup_rtr_pkg::*;
#(
    parameter int X_BITS = 2,
    parameter int Y_BITS = 2,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1
) (
    input  logic [X_BITS+Y_BITS-1:0] dst,
    output logic [NPORT-1:0]         dir
);
    logic [X_BITS-1:0] dx;
    logic [Y_BITS-1:0] dy;

    assign dx = dst[X_BITS-1:0];
    assign dy = dst[X_BITS+Y_BITS-1:X_BITS];

    // Pick one direction from the coordinate compare.
    always_comb begin
        dir = '0;
        if (dx > X_BITS'(MY_X))      dir[P_EAST]  = 1'b1;
        else if (dx < X_BITS'(MY_X)) dir[P_WEST]  = 1'b1;
        else if (dy > Y_BITS'(MY_Y)) dir[P_NORTH] = 1'b1;
        else if (dy < Y_BITS'(MY_Y)) dir[P_SOUTH] = 1'b1;
        else                         dir[P_LOC]   = 1'b1;
    end
endmodule

// File: rtl/setup_arb.sv
// Round-robin arbiter for one output port. The search starts just above the last winner.
// Assumes the pointer only moves when a grant is given.
module setup_arb #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [IW-1:0] last;

    // Find the first requester after the last winner.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last) + k) % N;
            if (!any && en && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                idx       = IW'(cand);
            end
        end
    end

    // Remember the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)   last <= IW'(N-1);
        else if (any) last <= idx;
    end
endmodule

// File: rtl/setup_router.sv
// Router of the circuit setup mesh. It has three stages: buffer write, arbitration, traversal.
// A winning request writes the data crossbar setting and updates the owner record.
// If it takes a link owned by another source, it also strobes a retag and emits a notification.
// Assumes single-flit packets and ready-based flow control toward the neighbours.
module setup_router
    import setup_rtr_pkg::*;
#(
    parameter int X_BITS = 2,
    parameter int Y_BITS = 2,
    parameter int NCIRC  = 4,
    parameter int DEPTH  = 4,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1,
    localparam int NW    = X_BITS + Y_BITS,
    localparam int CW    = $clog2(NCIRC),
    localparam int FW    = 1 + 2*NW + CW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            in_valid,
    input  logic [NPORT-1:0][FW-1:0]    in_flit,
    output logic [NPORT-1:0]            in_ready,
    output logic [NPORT-1:0]            out_valid,
    output logic [NPORT-1:0][FW-1:0]    out_flit,
    input  logic [NPORT-1:0]            out_ready,
    output logic [NPORT-1:0]            cfg_we,
    output logic [NPORT-1:0][CW-1:0]    cfg_circ,
    output logic [NPORT-1:0][PW-1:0]    cfg_in,
    output logic [NPORT-1:0]            rcf_valid,
    output logic [NPORT-1:0][CW-1:0]    rcf_circ,
    output logic [NPORT-1:0]            ntf_valid,
    output logic [NPORT-1:0][FW-1:0]    ntf_flit
);
    localparam logic [NW-1:0] MY_ID = {Y_BITS'(MY_Y), X_BITS'(MY_X)};

    logic [NPORT-1:0]                 head_v, pop;
    logic [NPORT-1:0][FW-1:0]         head_f;
    logic [NPORT-1:0][NPORT-1:0]      rt;       // rt[in][out]
    logic [NPORT-1:0][NPORT-1:0]      req, gnt; // [out][in]
    logic [NPORT-1:0][PW-1:0]         gidx;
    logic [NPORT-1:0]                 gany, out_free, sa_open, sa_v;
    logic [NPORT-1:0][FW-1:0]         sa_f, sel_f;
    logic [NPORT-1:0][CW-1:0]         sel_c;
    logic [NPORT-1:0][NW-1:0]         sel_s, old_s;
    logic [NPORT-1:0]                 sel_set, hit;
    logic [NCIRC-1:0][NPORT-1:0]      own_v;
    logic [NCIRC-1:0][NPORT-1:0][NW-1:0] own_src;

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_in
            setup_fifo #(.W(FW), .DEPTH(DEPTH)) u_buf (
                .clk(clk), .rst_n(rst_n),
                .push(in_valid[gi] && in_ready[gi]), .din(in_flit[gi]),
                .pop(pop[gi]), .dout(head_f[gi]), .nempty(head_v[gi]),
                .room(in_ready[gi])
            );
            setup_route #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt (
                .dst(head_f[gi][CW+NW-1:CW]), .dir(rt[gi])
            );
            setup_arb #(.N(NPORT), .IW(PW)) u_arb (
                .clk(clk), .rst_n(rst_n), .en(sa_open[gi]), .req(req[gi]),
                .gnt(gnt[gi]), .idx(gidx[gi]), .any(gany[gi])
            );
        end
    endgenerate

    // Request matrix, pops, and decode of the winning flit per output.
    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req[o][i] = head_v[i] && rt[i][o];
                pop[i]    = pop[i] | gnt[o][i];
            end
            out_free[o] = !out_valid[o] || out_ready[o];
            sa_open[o]  = !sa_v[o] || out_free[o];
            sel_f[o]    = head_f[gidx[o]];
            sel_c[o]    = sel_f[o][CW-1:0];
            sel_s[o]    = sel_f[o][CW+2*NW-1:CW+NW];
            sel_set[o]  = gany[o] && !sel_f[o][FW-1];
            old_s[o]    = own_src[sel_c[o]][o];
            hit[o]      = sel_set[o] && own_v[sel_c[o]][o] && (old_s[o] != sel_s[o]);
        end
    end

    // Pipeline stages, configuration strobes, and owner records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_v      <= '0;
            sa_f      <= '0;
            out_valid <= '0;
            out_flit  <= '0;
            cfg_we    <= '0;
            cfg_circ  <= '0;
            cfg_in    <= '0;
            rcf_valid <= '0;
            rcf_circ  <= '0;
            ntf_valid <= '0;
            ntf_flit  <= '0;
            own_v     <= '0;
            own_src   <= '0;
        end else begin
            for (int o = 0; o < NPORT; o++) begin
                if (out_free[o]) begin
                    out_valid[o] <= sa_v[o];
                    out_flit[o]  <= sa_f[o];
                end
                if (sa_open[o]) sa_v[o] <= gany[o];
                if (gany[o])    sa_f[o] <= sel_f[o];
                cfg_we[o]    <= sel_set[o];
                cfg_circ[o]  <= sel_c[o];
                cfg_in[o]    <= gidx[o];
                rcf_valid[o] <= hit[o];
                rcf_circ[o]  <= sel_c[o];
                ntf_valid[o] <= hit[o];
                ntf_flit[o]  <= {1'b1, MY_ID, old_s[o], sel_c[o]};
                if (sel_set[o]) begin
                    own_v[sel_c[o]][o]   <= 1'b1;
                    own_src[sel_c[o]][o] <= sel_s[o];
                end
            end
        end
    end
endmodule

// File: rtl/setup_router_chk.sv
// Checker for the setup router's output lanes. It is attached to every instance by bind.
// Assumes the same parameters as the router it watches.
module setup_router_chk
    import setup_rtr_pkg::*;
#(
    parameter int X_BITS = 2,
    parameter int Y_BITS = 2,
    parameter int NCIRC  = 4,
    localparam int NW    = X_BITS + Y_BITS,
    localparam int CW    = $clog2(NCIRC),
    localparam int FW    = 1 + 2*NW + CW
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORT-1:0]         out_valid,
    input logic [NPORT-1:0][FW-1:0] out_flit,
    input logic [NPORT-1:0]         out_ready,
    input logic [NPORT-1:0]         cfg_we,
    input logic [NPORT-1:0][CW-1:0] cfg_circ,
    input logic [NPORT-1:0]         rcf_valid,
    input logic [NPORT-1:0][CW-1:0] rcf_circ,
    input logic [NPORT-1:0]         ntf_valid,
    input logic [NPORT-1:0][FW-1:0] ntf_flit
);
    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_lane
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_flit[g]));
            p_rcf_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
                rcf_valid[g] |-> cfg_we[g] && (rcf_circ[g] == cfg_circ[g]));
            p_ntf_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ntf_valid[g] |-> rcf_valid[g] && ntf_flit[g][FW-1] && (ntf_flit[g][CW-1:0] == rcf_circ[g]));
            p_rcf_ntf_r6: assert property (@(posedge clk) disable iff (!rst_n)
                rcf_valid[g] |-> ntf_valid[g]);
            p_fwd_after_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we[g] && (!out_valid[g] || out_ready[g]) |=> out_valid[g]);
        end
    endgenerate
endmodule

bind setup_router setup_router_chk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .NCIRC(NCIRC)) u_chk (.*);

// File: tb/sim_setup_router.sv
// Scoreboard bench: driver tasks queue the expected flits and configuration writes.
// A monitor pops and compares them as the router produces them.
module sim_setup_router;
    localparam int NP = 5, XB = 2, YB = 2, NC = 4, NW = 4, CW = 2, FW = 11;
    localparam int MYID = 5;                 // node (x=1, y=1)
    localparam int CEW = CW + 3 + 2 + CW + FW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
    logic [NP-1:0][FW-1:0] in_flit = '0, out_flit, ntf_flit;
    logic [NP-1:0] cfg_we, rcf_valid, ntf_valid;
    logic [NP-1:0][CW-1:0] cfg_circ, rcf_circ;
    logic [NP-1:0][2:0] cfg_in;

    always #2 clk = ~clk;   // 250 MHz

    setup_router #(.X_BITS(XB), .Y_BITS(YB), .NCIRC(NC), .DEPTH(4), .MY_X(1), .MY_Y(1)) u0 (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;
    logic [FW-1:0]  out_q [NP][$];
    logic [CEW-1:0] cfg_q [NP][$];
    bit mv [NC][NP];
    int ms [NC][NP];
    logic [FW-1:0]  mon_e;
    logic [CEW-1:0] mon_c, mon_a;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input bit m, input int s, input int d, input int c);
        return {m, NW'(s), NW'(d), CW'(c)};
    endfunction

    function automatic int route(input int d);
        int x = d % 4, y = d / 4;
        if (x > 1) return 1;
        if (x < 1) return 2;
        if (y > 1) return 3;
        if (y < 1) return 4;
        return 0;
    endfunction

    // Queue what a flit accepted on input p must produce.
    task automatic expect_flit(input int p, input logic [FW-1:0] f);
        int o = route(int'(f[CW+NW-1:CW]));
        int c = int'(f[CW-1:0]);
        int s = int'(f[CW+2*NW-1:CW+NW]);
        bit h;
        out_q[o].push_back(f);
        if (!f[FW-1]) begin
            h = mv[c][o] && (ms[c][o] != s);
            cfg_q[o].push_back({CW'(c), 3'(p), h, h, h ? CW'(c) : CW'(0),
                                h ? mk(1, MYID, ms[c][o], c) : FW'(0)});
            mv[c][o] = 1;
            ms[c][o] = s;
        end
    endtask

    task automatic send(input int p, input logic [FW-1:0] f);
        @(negedge clk);
        while (!in_ready[p]) @(negedge clk);
        in_valid[p] = 1'b1;
        in_flit[p]  = f;
        expect_flit(p, f);
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic send2(input int p1, input logic [FW-1:0] f1, input int p2, input logic [FW-1:0] f2);
        @(negedge clk);
        chk(in_ready[p1] && in_ready[p2], "R8", in_ready, 5'h1f);
        in_valid[p1] = 1'b1; in_flit[p1] = f1;
        in_valid[p2] = 1'b1; in_flit[p2] = f2;
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic drain();
        for (int k = 0; k < 100; k++) begin
            int n = 0;
            @(negedge clk);
            for (int o = 0; o < NP; o++) n += out_q[o].size() + cfg_q[o].size();
            if (n == 0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int c = 0; c < NC; c++) for (int o = 0; o < NP; o++) begin mv[c][o] = 0; ms[c][o] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs against the queues just after each negedge.
    always begin
        @(negedge clk); #1;
        if (rst_n) for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o]) begin
                if (out_q[o].size() == 0) chk(0, "R2 unexpected flit", out_flit[o], 0);
                else begin
                    mon_e = out_q[o].pop_front();
                    chk(out_flit[o] == mon_e, "R2 flit", out_flit[o], mon_e);
                end
            end
            if (cfg_we[o]) begin
                mon_a = {cfg_circ[o], cfg_in[o], rcf_valid[o], ntf_valid[o],
                         rcf_valid[o] ? rcf_circ[o] : CW'(0), rcf_valid[o] ? ntf_flit[o] : FW'(0)};
                if (cfg_q[o].size() == 0) chk(0, "R7 unexpected cfg_we", mon_a, 0);
                else begin
                    mon_c = cfg_q[o].pop_front();
                    chk(mon_a == mon_c, "R4 R5 cfg/retag", mon_a, mon_c);
                end
            end else if (rcf_valid[o] || ntf_valid[o])
                chk(0, "R6 retag without cfg", {rcf_valid[o], ntf_valid[o]}, 0);
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        while (cyc < 50000) begin @(posedge clk); cyc++; end
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int acc;
        logic [FW-1:0] f;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk((cfg_we | rcf_valid | ntf_valid) == 0, "R1 strobes", {cfg_we, rcf_valid, ntf_valid}, 0);
        chk(in_ready == 5'h1f, "R1 in_ready", in_ready, 5'h1f);
        do_reset();

        // R2 routing in every direction, x first; R6 repeat by same source
        send(0, mk(0, 5, 6, 0));
        send(0, mk(0, 5, 4, 0));
        send(0, mk(0, 5, 9, 0));
        send(0, mk(0, 5, 1, 0));
        send(0, mk(0, 5, 5, 0));
        send(0, mk(0, 5, 14, 0));
        drain();

        // R3 exact latency of an uncontended request
        @(negedge clk);
        f = mk(0, 4, 7, 1);
        in_valid[2] = 1'b1; in_flit[2] = f;
        expect_flit(2, f);
        @(negedge clk); in_valid[2] = 1'b0; #1;
        chk(cfg_we[1] == 0 && out_valid[1] == 0, "R3 edge k", {cfg_we[1], out_valid[1]}, 0);
        @(negedge clk); #1;
        chk(cfg_we[1] == 1 && out_valid[1] == 0, "R3 cfg at k+1", {cfg_we[1], out_valid[1]}, 2'b10);
        @(negedge clk); #1;
        chk(out_valid[1] == 1 && cfg_we[1] == 0, "R3 out at k+2", {cfg_we[1], out_valid[1]}, 2'b01);
        drain();

        // R5 takeover of plane 1 east by source 13; R6 repeat by new owner
        send(3, mk(0, 13, 6, 1));
        send(3, mk(0, 13, 6, 1));
        // R10 other planes on the same link stay independent
        send(4, mk(0, 8, 7, 2));
        send(4, mk(0, 9, 7, 3));
        send(4, mk(0, 8, 7, 2));
        drain();

        // R7 notifications: no cfg write, records untouched
        send(2, mk(1, 2, 6, 2));
        send(0, mk(1, 1, 5, 3));
        send(4, mk(0, 8, 7, 2));
        send(3, mk(0, 9, 6, 3));
        drain();

        // R9 stalled output: hold and buffer depth
        out_ready[3] = 1'b0;
        acc = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (in_ready[4]) begin
                f = mk(1, 3, 9, k % 4);
                in_valid[4] = 1'b1; in_flit[4] = f;
                expect_flit(4, f);
                acc++;
            end else in_valid[4] = 1'b0;
        end
        @(negedge clk); in_valid[4] = 1'b0;
        chk(acc == 6, "R9 accepted while stalled", acc, 6);
        chk(out_valid[3] && out_flit[3] == mk(1, 3, 9, 0), "R9 hold", out_flit[3], mk(1, 3, 9, 0));
        out_ready[3] = 1'b1;
        drain();

        // R8 round robin after a fresh reset
        do_reset();
        out_ready[0] = 1'b0;
        send2(1, mk(1, 1, 5, 0), 3, mk(1, 3, 5, 0));
        out_q[0].push_back(mk(1, 1, 5, 0));
        out_q[0].push_back(mk(1, 3, 5, 0));
        repeat (3) @(negedge clk);
        out_ready[0] = 1'b1;
        drain();
        send2(4, mk(1, 4, 5, 1), 1, mk(1, 1, 5, 1));
        out_q[0].push_back(mk(1, 4, 5, 1));
        out_q[0].push_back(mk(1, 1, 5, 1));
        drain();

        begin
            int n = 0;
            for (int o = 0; o < NP; o++) n += out_q[o].size() + cfg_q[o].size();
            chk(n == 0, "R2 scoreboard empty", n, 0);
        end
        summary();
    end
endmodule